// File: doc/BRIEF.md
# Coarse and Fine Delay Splitter

This block turns an already evaluated per-sample delay into the two forms a
beam-steering pipeline needs. The delay arrives as an unsigned fixed-point
number of input samples. Its integer part becomes a whole-sample offset added to
the read pointer of a triple-buffered sample store. The integer part is taken
only on the first sample of a frame and stays fixed until the next frame. Its
fractional part is refreshed on every sample. That part is multiplied by the
sky frequency to give a phase offset, and by the per-bin frequency step to give
a phase slope across the channel. A downstream rotator applies both.

The block also checks two validity windows, one for the station delay model and
one for the beam delay model, against the current time. It raises a flag when
either window does not cover that time. All results appear together, two clock
cycles after the sample strobe, with a one-cycle valid pulse.

Top module: `dly_split_top`

## Requirements
- R1: `delayIn` is unsigned, with INT_W integer bits above FRAC_W fractional bits (20 and 16 by default). Only the fractional bits affect the phase outputs, and only the integer bits affect the read address.
- R2: The coarse delay is loaded from the integer bits only on a sample where `sampleStrobe` and `frameStart` are both high, and that same sample already uses the new value. Every other sample uses the held value, which is 0 after reset.
- R3: `rdAddr` equals (`rdBase` + coarse delay) modulo DEPTH, where DEPTH = NUM_FRAMES × PKTS_PER_FRAME × SAMPLES_PER_PKT. It is always below DEPTH.
- R4: `phaseOffset` is bits [FRAC_W+FREQ_FRAC-1 : FRAC_W+FREQ_FRAC-PHASE_W] of the product of the fraction and `skyFreq`. `skyFreq` is unsigned, in cycles per input sample, with FREQ_FRAC = 8 fractional bits. The phase is an unsigned 16-bit count of turns, so it wraps modulo one turn.
- R5: `phaseSlope` is built in the same way as R4 from the fraction times `binStep`, the frequency step between adjacent fine bins.
- R6: Both phase outputs are recomputed on every sample, including samples in the middle of a frame.
- R7: A window is valid when start ≤ `nowTime` < end (unsigned). `delayBad` is 1 when the station window or the beam window is not valid.
- R8: `outValid` pulses high exactly two cycles after each `sampleStrobe`. The outputs hold their values between results.
- R9: After reset, `outValid`, `rdAddr`, `phaseOffset`, `phaseSlope` and `delayBad` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sampleStrobe | input | 1 | One input sample to process |
| frameStart | input | 1 | This sample opens a frame (qualified by sampleStrobe) |
| delayIn | input | INT_W+FRAC_W | Total delay in samples, fixed point |
| rdBase | input | ADDR_W | Nominal read pointer before the delay |
| skyFreq | input | FREQ_W | Sky frequency, U(FREQ_W-8).8 cycles/sample |
| binStep | input | FREQ_W | Frequency step per fine bin, same format |
| nowTime | input | TIME_W | Current time |
| stnStart | input | TIME_W | Station model valid-from time |
| stnEnd | input | TIME_W | Station model valid-until time (exclusive) |
| beamStart | input | TIME_W | Beam model valid-from time |
| beamEnd | input | TIME_W | Beam model valid-until time (exclusive) |
| outValid | output | 1 | Result strobe |
| rdAddr | output | ADDR_W | Delayed read address |
| phaseOffset | output | PHASE_W | Phase offset in turns/2^16 |
| phaseSlope | output | PHASE_W | Phase increment per fine bin |
| delayBad | output | 1 | A delay model is outside its window |

## Verification
The bench builds the block with 4 samples per packet, 2 packets per frame and 3 frames, so the store is only 24 deep. Modulo wrap of the read address is then reached with small bases, and also with coarse delays many times the depth. The default 20.16 delay and 16-bit frequency widths are kept. A sweep of 16 fractions against 6 frequencies runs through phase wraparound at the true widths. Frame captures and mid-frame samples are interleaved to show that the coarse value holds. Time values are placed exactly on each window edge.

// File: rtl/dly_pkg.sv
package dly_pkg;
  // Strobes handed from control to datapath
  typedef struct packed {
    logic load1;    // stage 1 takes a new sample
    logic capture;  // stage 1 reloads the frame coarse delay
    logic load2;    // stage 2 registers results
  } dlyStrobe_t;
endpackage

// File: rtl/dly_ctrl.sv
module dly_ctrl import dly_pkg::*; #(
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sampleStrobe,
  input  logic              frameStart,
  input  logic [TIME_W-1:0] nowTime,
  input  logic [TIME_W-1:0] stnStart,
  input  logic [TIME_W-1:0] stnEnd,
  input  logic [TIME_W-1:0] beamStart,
  input  logic [TIME_W-1:0] beamEnd,
  output dlyStrobe_t        strb,
  output logic              outValid,
  output logic              delayBad
);
  logic stage1Valid;
  logic stnOk, beamOk;
  logic badStage1;

  // half-open windows [start, end)
  always_comb begin
    stnOk  = (nowTime >= stnStart)  && (nowTime < stnEnd);
    beamOk = (nowTime >= beamStart) && (nowTime < beamEnd);
  end

  always_comb begin
    strb.load1   = sampleStrobe;
    strb.capture = sampleStrobe && frameStart;
    strb.load2   = stage1Valid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1Valid <= 1'b0;
      outValid    <= 1'b0;
      badStage1   <= 1'b0;
      delayBad    <= 1'b0;
    end else begin
      stage1Valid <= sampleStrobe;
      outValid    <= stage1Valid;
      if (sampleStrobe) badStage1 <= !(stnOk && beamOk);
      if (stage1Valid)  delayBad  <= badStage1;
    end
  end
endmodule

// File: rtl/dly_datapath.sv
module dly_datapath import dly_pkg::*; #(
  parameter int INT_W     = 20,
  parameter int FRAC_W    = 16,
  parameter int FREQ_W    = 16,
  parameter int FREQ_FRAC = 8,
  parameter int PHASE_W   = 16,
  parameter int DEPTH     = 196608,
  parameter int ADDR_W    = 18
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  dlyStrobe_t              strb,
  input  logic [INT_W+FRAC_W-1:0] delayIn,
  input  logic [ADDR_W-1:0]       rdBase,
  input  logic [FREQ_W-1:0]       skyFreq,
  input  logic [FREQ_W-1:0]       binStep,
  output logic [ADDR_W-1:0]       rdAddr,
  output logic [PHASE_W-1:0]      phaseOffset,
  output logic [PHASE_W-1:0]      phaseSlope
);
  localparam int SUM_W  = ((INT_W > ADDR_W) ? INT_W : ADDR_W) + 1;
  localparam int PROD_W = FRAC_W + FREQ_W;
  localparam int PH_LSB = FRAC_W + FREQ_FRAC - PHASE_W;

  logic [INT_W-1:0]  coarseHeld, coarseUse, coarseNext;
  logic [FRAC_W-1:0] fracQ;
  logic [FREQ_W-1:0] freqQ, stepQ;
  logic [ADDR_W-1:0] baseQ;

  logic [SUM_W-1:0]  sumW, modW;
  logic [PROD_W-1:0] prodOff, prodSlope;

  assign coarseNext = strb.capture ? delayIn[FRAC_W +: INT_W] : coarseHeld;

  // stage 1: split delay, pick frame coarse value
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coarseHeld <= '0;
      coarseUse  <= '0;
      fracQ      <= '0;
      freqQ      <= '0;
      stepQ      <= '0;
      baseQ      <= '0;
    end else if (strb.load1) begin
      coarseHeld <= coarseNext;
      coarseUse  <= coarseNext;
      fracQ      <= delayIn[FRAC_W-1:0];
      freqQ      <= skyFreq;
      stepQ      <= binStep;
      baseQ      <= rdBase;
    end
  end

  always_comb begin
    sumW      = SUM_W'(baseQ) + SUM_W'(coarseUse);
    modW      = sumW % SUM_W'(DEPTH);
    prodOff   = PROD_W'(fracQ) * PROD_W'(freqQ);
    prodSlope = PROD_W'(fracQ) * PROD_W'(stepQ);
  end

  // stage 2: wrapped address and phases in turns
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdAddr      <= '0;
      phaseOffset <= '0;
      phaseSlope  <= '0;
    end else if (strb.load2) begin
      rdAddr      <= modW[ADDR_W-1:0];
      phaseOffset <= prodOff[PH_LSB +: PHASE_W];
      phaseSlope  <= prodSlope[PH_LSB +: PHASE_W];
    end
  end
endmodule

// File: rtl/dly_split_top.sv
module dly_split_top import dly_pkg::*; #(
  parameter int INT_W           = 20,
  parameter int FRAC_W          = 16,
  parameter int FREQ_W          = 16,
  parameter int PHASE_W         = 16,
  parameter int TIME_W          = 32,
  parameter int SAMPLES_PER_PKT = 2048,
  parameter int PKTS_PER_FRAME  = 32,
  parameter int NUM_FRAMES      = 3,
  localparam int DEPTH  = SAMPLES_PER_PKT * PKTS_PER_FRAME * NUM_FRAMES,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sampleStrobe,
  input  logic                    frameStart,
  input  logic [INT_W+FRAC_W-1:0] delayIn,
  input  logic [ADDR_W-1:0]       rdBase,
  input  logic [FREQ_W-1:0]       skyFreq,
  input  logic [FREQ_W-1:0]       binStep,
  input  logic [TIME_W-1:0]       nowTime,
  input  logic [TIME_W-1:0]       stnStart,
  input  logic [TIME_W-1:0]       stnEnd,
  input  logic [TIME_W-1:0]       beamStart,
  input  logic [TIME_W-1:0]       beamEnd,
  output logic                    outValid,
  output logic [ADDR_W-1:0]       rdAddr,
  output logic [PHASE_W-1:0]      phaseOffset,
  output logic [PHASE_W-1:0]      phaseSlope,
  output logic                    delayBad
);
  dlyStrobe_t strb;

  dly_ctrl #(.TIME_W(TIME_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sampleStrobe(sampleStrobe),
    .frameStart(frameStart), .nowTime(nowTime),
    .stnStart(stnStart), .stnEnd(stnEnd),
    .beamStart(beamStart), .beamEnd(beamEnd),
    .strb(strb), .outValid(outValid), .delayBad(delayBad)
  );

  dly_datapath #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .FREQ_W(FREQ_W), .FREQ_FRAC(8),
    .PHASE_W(PHASE_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .delayIn(delayIn),
    .rdBase(rdBase), .skyFreq(skyFreq), .binStep(binStep),
    .rdAddr(rdAddr), .phaseOffset(phaseOffset), .phaseSlope(phaseSlope)
  );
endmodule

// File: rtl/dly_split_chk.sv
module dly_split_chk #(
  parameter int INT_W   = 20,
  parameter int FRAC_W  = 16,
  parameter int PHASE_W = 16,
  parameter int TIME_W  = 32,
  parameter int DEPTH   = 196608,
  parameter int ADDR_W  = 18
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sampleStrobe,
  input logic [INT_W+FRAC_W-1:0] delayIn,
  input logic [TIME_W-1:0]       nowTime,
  input logic [TIME_W-1:0]       stnStart,
  input logic [TIME_W-1:0]       beamEnd,
  input logic                    outValid,
  input logic [ADDR_W-1:0]       rdAddr,
  input logic [PHASE_W-1:0]      phaseOffset,
  input logic [PHASE_W-1:0]      phaseSlope,
  input logic                    delayBad
);
  logic [1:0] sinceRst;
  always_ff @(posedge clk) begin
    if (!rst_n) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end
  logic warm;
  assign warm = (sinceRst >= 2'd2);

  // R8
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (outValid == $past(sampleStrobe, 2)));

  // R8
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !outValid) |-> ($stable(rdAddr) && $stable(phaseOffset)
                             && $stable(phaseSlope) && $stable(delayBad)));

  // R3
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdAddr < ADDR_W'(DEPTH));

  // R4
  zero_frac_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(sampleStrobe && (delayIn[FRAC_W-1:0] == '0), 2))
      |-> (phaseOffset == '0 && phaseSlope == '0));

  // R7
  early_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(sampleStrobe && (nowTime < stnStart), 2)) |-> delayBad);

  // R7
  late_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(sampleStrobe && (nowTime >= beamEnd), 2)) |-> delayBad);
endmodule

bind dly_split_top dly_split_chk #(
  .INT_W(INT_W), .FRAC_W(FRAC_W), .PHASE_W(PHASE_W), .TIME_W(TIME_W),
  .DEPTH(DEPTH), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sampleStrobe(sampleStrobe), .delayIn(delayIn),
  .nowTime(nowTime), .stnStart(stnStart), .beamEnd(beamEnd),
  .outValid(outValid), .rdAddr(rdAddr), .phaseOffset(phaseOffset),
  .phaseSlope(phaseSlope), .delayBad(delayBad)
);

// File: tb/dly_split_top_tb.sv
module dly_split_top_tb;
  localparam int INT_W = 20, FRAC_W = 16, FREQ_W = 16, PHASE_W = 16, TIME_W = 16;
  localparam int SPP = 4, PPF = 2, NF = 3;
  localparam int DEPTH = SPP * PPF * NF;
  localparam int ADDR_W = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sampleStrobe = 1'b0, frameStart = 1'b0;
  logic [INT_W+FRAC_W-1:0] delayIn = '0;
  logic [ADDR_W-1:0] rdBase = '0;
  logic [FREQ_W-1:0] skyFreq = '0, binStep = '0;
  logic [TIME_W-1:0] nowTime = '0, stnStart = '0, stnEnd = '1, beamStart = '0, beamEnd = '1;
  logic outValid, delayBad;
  logic [ADDR_W-1:0] rdAddr;
  logic [PHASE_W-1:0] phaseOffset, phaseSlope;

  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dly_split_top #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .FREQ_W(FREQ_W), .PHASE_W(PHASE_W),
    .TIME_W(TIME_W), .SAMPLES_PER_PKT(SPP), .PKTS_PER_FRAME(PPF), .NUM_FRAMES(NF)
  ) u_dut (.*);

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint expPhase(longint frac, longint f);
    return ((frac * f) >> 8) & 16'hFFFF;
  endfunction

  // drives one sample at a negedge, returns after outputs are registered
  task automatic doSample(input longint intPart, input longint frac, input bit fs,
                          input longint base, input longint f, input longint st);
    @(negedge clk);
    delayIn = {intPart[INT_W-1:0], frac[FRAC_W-1:0]};
    frameStart = fs; rdBase = base[ADDR_W-1:0];
    skyFreq = f[FREQ_W-1:0]; binStep = st[FREQ_W-1:0];
    sampleStrobe = 1'b1;
    @(negedge clk);
    sampleStrobe = 1'b0; frameStart = 1'b0;
    delayIn = '1; skyFreq = '1; binStep = '1;
    @(negedge clk);
    check("R8 valid", outValid, 1);
  endtask

  initial begin
    longint coarse;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 valid", outValid, 0);
    check("R9 addr", rdAddr, 0);
    check("R9 offset", phaseOffset, 0);
    check("R9 slope", phaseSlope, 0);
    check("R9 flag", delayBad, 0);
    rst_n = 1'b1;

    // R2 no capture yet: coarse 0, integer bits ignored
    doSample(7, 0, 0, 5, 0, 0);
    check("R2 pre-capture addr", rdAddr, 5);
    @(negedge clk);
    check("R8 single pulse", outValid, 0);
    check("R8 hold", rdAddr, 5);

    // R2 capture then hold mid-frame
    doSample(5, 0, 1, 2, 0, 0);
    check("R2 capture addr", rdAddr, 7);
    doSample(9, 0, 0, 2, 0, 0);
    check("R2 hold addr", rdAddr, 7);
    doSample(9, 0, 1, 2, 0, 0);
    check("R2 recapture addr", rdAddr, 11);

    // R3 wrap modulo depth, including coarse many times depth
    doSample(5, 0, 1, 22, 0, 0);
    check("R3 wrap", rdAddr, (22 + 5) % DEPTH);
    doSample(1000, 0, 1, 13, 0, 0);
    check("R3 big coarse", rdAddr, (13 + 1000) % DEPTH);
    doSample(20'hFFFFF, 0, 1, 23, 0, 0);
    check("R3 max coarse", rdAddr, (23 + 20'hFFFFF) % DEPTH);

    // R1 R4 R5 R6 sweep, frame capture only on first sample
    coarse = 3;
    for (int fi = 0; fi < 16; fi++) begin
      for (int qi = 0; qi < 6; qi++) begin
        longint frac = (fi * 4099 + 1) & 16'hFFFF;
        longint f    = (qi * 12011 + 257) & 16'hFFFF;
        longint st   = (qi * 733 + fi * 17 + 1) & 16'hFFFF;
        bit fs = (fi == 0 && qi == 0);
        doSample(fs ? coarse : coarse + fi + 1, frac, fs, fi, f, st);
        check("R4 offset", phaseOffset, expPhase(frac, f));
        check("R5 slope", phaseSlope, expPhase(frac, st));
        check("R1 R6 addr from coarse only", rdAddr, (fi + coarse) % DEPTH);
      end
    end
    // R4 wrap at one full turn: frac 0.5 times 2.0 cycles gives 0
    doSample(0, 16'h8000, 0, 0, 16'h0200, 16'h0100);
    check("R4 full-turn wrap", phaseOffset, 0);
    check("R5 half turn", phaseSlope, 16'h8000);

    // R7 window edges
    stnStart = 100; stnEnd = 200; beamStart = 50; beamEnd = 300;
    nowTime = 99;  doSample(0, 0, 0, 0, 0, 0); check("R7 before stn start", delayBad, 1);
    nowTime = 100; doSample(0, 0, 0, 0, 0, 0); check("R7 at stn start", delayBad, 0);
    nowTime = 199; doSample(0, 0, 0, 0, 0, 0); check("R7 inside", delayBad, 0);
    nowTime = 200; doSample(0, 0, 0, 0, 0, 0); check("R7 at stn end", delayBad, 1);
    stnEnd = 400;
    nowTime = 300; doSample(0, 0, 0, 0, 0, 0); check("R7 at beam end", delayBad, 1);
    nowTime = 299; doSample(0, 0, 0, 0, 0, 0); check("R7 both ok", delayBad, 0);
    beamStart = 299; stnStart = 300;
    doSample(0, 0, 0, 0, 0, 0); check("R7 stn only bad", delayBad, 1);
    @(negedge clk);
    check("R8 flag holds", delayBad, 1);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule